// File: doc/BRIEF.md
# Page Write Buffer and Commit Timer

This block sits between a two-wire serial slave front-end and a non-volatile byte array. During a write transaction the front-end hands it the word address once and then one strobe per received data byte. The block keeps those bytes in a small page buffer and leaves the array untouched while the transaction is still open. A byte lands in slot `count mod PAGE_BYTES`. A ninth or later byte therefore overwrites the oldest slot, and its target address wraps inside the same page.

A STOP event with at least one buffered byte starts a commit. The block raises `busy` on the next cycle and writes the buffered bytes to the array, one per clock, in slot order. It keeps `busy` high for a fixed, parameterised number of clock cycles, which stands in for the programming time of the array. A START event that is not accompanied by STOP drops the buffered bytes. Examples are a repeated START, or the START that opens a random read after a dummy write. While `busy` is high, every front-end input is ignored. The front-end uses `busy` to refuse acknowledgement of its device address.

Top module: `page_commit_unit`

## Requirements
- R1: After reset `busy` and `mem_we` are both low.
- R2: While bytes are collected, and until a STOP, `mem_we` and `busy` stay low.
- R3: A STOP after n buffered bytes (1 ≤ n ≤ PAGE_BYTES) raises `busy` on the next clock. In the first n cycles of `busy`, `mem_we` is high on consecutive cycles. Write i carries the i-th byte to address {base[7:3], (base[2:0]+i) mod 8}, where base is the loaded word address.
- R4: When more than PAGE_BYTES bytes arrive, exactly PAGE_BYTES writes are made. Write i carries the latest byte k with k mod 8 = i, to offset (base+i) mod 8 of the same page.
- R5: A START without STOP discards the buffer. A later STOP with no new bytes starts no commit.
- R6: `busy` stays high for exactly WR_CYCLES cycles per commit, with WR_CYCLES ≥ PAGE_BYTES.
- R7: While `busy` is high, pointer loads, byte strobes, START and STOP have no effect. After a commit the buffer is empty, so a lone STOP then starts nothing.
- R8: A STOP after only a word address and no data bytes starts no commit.
- R9: A byte strobe in the same cycle as STOP is included in the commit as the last byte.
- R10: START and STOP in the same cycle act as STOP, and the buffered bytes are committed.
- R11: A single byte followed by STOP, a byte write, goes through the same commit with one array write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_ld | input | 1 | Strobe: load word address from `ptr_addr`, empty the buffer |
| ptr_addr | input | ADDR_W | Word address received from the master |
| byte_vld | input | 1 | Strobe: one data byte received |
| byte_data | input | DATA_W | Received data byte |
| evt_start | input | 1 | START or repeated START seen on the bus |
| evt_stop | input | 1 | STOP seen on the bus |
| busy | output | 1 | Internally timed write in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |

## Verification
Two pairs of events can fall into one clock cycle. The first is a byte strobe arriving on the same edge as the STOP that closes the transaction. The second is START arriving on the same edge as STOP. The bench sweeps every page offset and byte count from 1 to 11. On every odd count it raises the final byte strobe together with STOP, and it judges that the commit has exactly the expected number of writes, with the last data byte in its wrapped slot. A separate transaction raises START and STOP together and checks that the commit still happens.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic {
    CM_IDLE = 1'b0,
    CM_BUSY = 1'b1
  } cm_state_e;

endpackage

// File: rtl/pcu_store.sv
// Page buffer: word address, write pointer, slot storage.
// PAGE_BYTES must be a power of two so the slot pointer wraps naturally.
module pcu_store #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 8,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int CNT_W     = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              clr,
  input  logic              ptr_ld,
  input  logic [ADDR_W-1:0] ptr_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic [OFF_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] base_addr,
  output logic [CNT_W-1:0]  fill_nxt,
  output logic [DATA_W-1:0] rd_data
);

  logic [ADDR_W-1:0] base_q, base_d;
  logic [OFF_W-1:0]  wp_q, wp_d;
  logic              full_q, full_d;
  logic              slot_we;
  logic [DATA_W-1:0] slot_q [PAGE_BYTES];

  always_comb begin
    base_d  = base_q;
    wp_d    = wp_q;
    full_d  = full_q;
    slot_we = 1'b0;
    if (clr) begin
      wp_d   = '0;
      full_d = 1'b0;
    end else if (en && ptr_ld) begin
      base_d = ptr_addr;
      wp_d   = '0;
      full_d = 1'b0;
    end else if (en && byte_vld) begin
      slot_we = 1'b1;
      wp_d    = wp_q + 1'b1;
      if (wp_q == OFF_W'(PAGE_BYTES - 1)) full_d = 1'b1;
    end
  end

  assign fill_nxt  = full_d ? CNT_W'(PAGE_BYTES) : CNT_W'(wp_d);
  assign base_addr = base_q;
  assign rd_data   = slot_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      wp_q   <= '0;
      full_q <= 1'b0;
    end else begin
      base_q <= base_d;
      wp_q   <= wp_d;
      full_q <= full_d;
    end
  end

  for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (slot_we && (wp_q == OFF_W'(s))) slot_q[s] <= byte_data;
    end
  end

  // R7: with inputs blocked and no clear, the buffer state holds
  a_r7_hold_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> ($stable(base_q) && $stable(wp_q) && $stable(full_q)));

  // R4: once full, further bytes keep it full until cleared or reloaded
  a_r4_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !clr && !(en && ptr_ld)) |=> full_q);

endmodule

// File: rtl/pcu_commit.sv
// Commit sequencer: one array write per cycle plus the fixed write timer.
module pcu_commit
  import pcu_pkg::*;
#(
  parameter int PAGE_BYTES = 8,
  parameter int WR_CYCLES  = 20,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int CNT_W     = OFF_W + 1,
  localparam int TMR_W     = $clog2(WR_CYCLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CNT_W-1:0] n_in,
  output logic             busy,
  output logic             we,
  output logic [OFF_W-1:0] idx,
  output logic             done
);

  cm_state_e        st_q, st_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] n_q, n_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             tmr_fin, wr_fin;

  assign busy    = (st_q == CM_BUSY);
  assign we      = busy && (idx_q < n_q);
  assign idx     = idx_q[OFF_W-1:0];
  assign tmr_fin = (tmr_q == TMR_W'(WR_CYCLES - 1));
  assign wr_fin  = ((CNT_W+1)'(idx_q) + (CNT_W+1)'(1)) >= (CNT_W+1)'(n_q);
  assign done    = busy && tmr_fin && wr_fin;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    n_d   = n_q;
    tmr_d = tmr_q;
    if (!busy && go) begin
      st_d  = CM_BUSY;
      idx_d = '0;
      n_d   = n_in;
      tmr_d = '0;
    end else if (busy) begin
      if (done) st_d = CM_IDLE;
      if (we) idx_d = idx_q + 1'b1;
      if (!tmr_fin) tmr_d = tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CM_IDLE;
      idx_q <= '0;
      n_q   <= '0;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      n_q   <= n_d;
      tmr_q <= tmr_d;
    end
  end

  // R6: busy cannot end before the timer has run out
  a_r6_busy_span: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tmr_fin) |=> busy);

  // R3: when busy ends, every buffered byte has been written
  a_r3_all_written: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (((CNT_W+1)'(idx_q) + (CNT_W+1)'(we)) == (CNT_W+1)'(n_q)));

  // R3: a commit never starts empty
  a_r3_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (n_q != '0));

endmodule

// File: rtl/page_commit_unit.sv
module page_commit_unit #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 8,
  parameter int WR_CYCLES  = 20,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int CNT_W     = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_ld,
  input  logic [ADDR_W-1:0] ptr_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              evt_start,
  input  logic              evt_stop,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);

  logic              accept;
  logic              buf_clr;
  logic              go;
  logic              cm_done;
  logic [OFF_W-1:0]  wr_idx;
  logic [ADDR_W-1:0] base_addr;
  logic [CNT_W-1:0]  fill_nxt;
  logic [OFF_W-1:0]  off_sum;

  assign accept  = !busy;
  // STOP wins over START in the same cycle (R10)
  assign go      = accept && evt_stop && (fill_nxt != '0);
  assign buf_clr = (accept && evt_start && !evt_stop) || cm_done;

  pcu_store #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (accept),
    .clr      (buf_clr),
    .ptr_ld   (ptr_ld),
    .ptr_addr (ptr_addr),
    .byte_vld (byte_vld),
    .byte_data(byte_data),
    .rd_idx   (wr_idx),
    .base_addr(base_addr),
    .fill_nxt (fill_nxt),
    .rd_data  (mem_wdata)
  );

  pcu_commit #(
    .PAGE_BYTES(PAGE_BYTES),
    .WR_CYCLES (WR_CYCLES)
  ) u_commit (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (go),
    .n_in (fill_nxt),
    .busy (busy),
    .we   (mem_we),
    .idx  (wr_idx),
    .done (cm_done)
  );

  assign off_sum  = base_addr[OFF_W-1:0] + wr_idx;
  assign mem_addr = {base_addr[ADDR_W-1:OFF_W], off_sum};

  // R2: the array is only written inside a commit
  a_r2_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we);

  // R3: busy only rises after a STOP
  a_r3_rise_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(evt_stop));

  // R7: a new commit cannot be launched from inside a commit
  a_r7_no_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cm_done) |=> busy);

endmodule

// File: tb/tb_page_commit_unit.sv
module tb_page_commit_unit;

  localparam int WR = 20;

  logic       clk;
  logic       rst_n;
  logic       ptr_ld;
  logic [7:0] ptr_addr;
  logic       byte_vld;
  logic [7:0] byte_data;
  logic       evt_start;
  logic       evt_stop;
  logic       busy;
  logic       mem_we;
  logic [7:0] mem_addr;
  logic [7:0] mem_wdata;

  int n_run;
  int n_fail;
  int got_n;
  int busy_len;
  logic [7:0] got_addr [16];
  logic [7:0] got_data [16];

  page_commit_unit #(
    .ADDR_W(8), .DATA_W(8), .PAGE_BYTES(8), .WR_CYCLES(WR)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ptr_ld(ptr_ld), .ptr_addr(ptr_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .evt_start(evt_start),
    .evt_stop(evt_stop), .busy(busy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_drive();
    ptr_ld = 0; ptr_addr = 0; byte_vld = 0; byte_data = 0;
    evt_start = 0; evt_stop = 0;
  endtask

  // one-cycle pulse; R2 sampled before each pulse of a collection phase
  task automatic pulse(input bit ld, input logic [7:0] a, input bit bv,
                       input logic [7:0] d, input bit st, input bit sp,
                       inout bit pre_bad);
    if (busy || mem_we) pre_bad = 1;
    ptr_ld = ld; ptr_addr = a; byte_vld = bv; byte_data = d;
    evt_start = st; evt_stop = sp;
    @(negedge clk);
    idle_drive();
  endtask

  task automatic run_commit(input bit inject);
    int guard = 0;
    got_n = 0; busy_len = 0;
    while (busy && guard < 200) begin
      busy_len++;
      if (mem_we && got_n < 16) begin
        got_addr[got_n] = mem_addr;
        got_data[got_n] = mem_wdata;
        got_n++;
      end
      if (inject) begin
        ptr_ld = 1; ptr_addr = 8'hEE; byte_vld = 1; byte_data = 8'hA5;
        evt_stop = busy_len[0]; evt_start = ~busy_len[0];
      end
      guard++;
      @(negedge clk);
    end
    idle_drive();
  endtask

  task automatic expect_quiet(input int cyc, input string req);
    bit bad = 0;
    for (int c = 0; c < cyc; c++) begin
      if (busy || mem_we) bad = 1;
      @(negedge clk);
    end
    chk(!bad, req, bad, 0);
  endtask

  function automatic logic [7:0] dval(input int off, input int n, input int k);
    return 8'((off * 37 + n * 11 + k * 5 + 3) & 255);
  endfunction

  task automatic check_commit(input logic [7:0] base, input int n,
                              input int off, input string req);
    int m = (n < 8) ? n : 8;
    chk(got_n == m, req, got_n, m);
    chk(busy_len == WR, "R6", busy_len, WR);
    for (int i = 0; i < m; i++) begin
      int k = i + 8 * ((n - 1 - i) / 8);
      logic [7:0] ea = {base[7:3], 3'(base[2:0] + 3'(i))};
      logic [7:0] ed = dval(off, n, k);
      chk(got_addr[i] == ea, req, got_addr[i], ea);
      chk(got_data[i] == ed, req, got_data[i], ed);
    end
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit pb;
    logic [7:0] base;
    n_run = 0; n_fail = 0;
    idle_drive();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 0, "R1", busy, 0);
    chk(mem_we == 0, "R1", mem_we, 0);
    rst_n = 1;
    @(negedge clk);

    // R3 R4 R9 R2: sweep offsets and counts; odd counts put last byte on STOP
    for (int off = 0; off < 8; off++) begin
      for (int n = 1; n <= 11; n++) begin
        pb = 0;
        base = {5'((off + n) & 31), 3'(off)};
        pulse(0, 0, 0, 0, 1, 0, pb);
        pulse(1, base, 0, 0, 0, 0, pb);
        for (int k = 0; k < n - (n % 2); k++) pulse(0, 0, 1, dval(off, n, k), 0, 0, pb);
        if (n % 2 == 1) pulse(0, 0, 1, dval(off, n, n - 1), 0, 1, pb);  // R9
        else pulse(0, 0, 0, 0, 0, 1, pb);
        chk(pb == 0, "R2", pb, 0);
        chk(busy == 1, "R3", busy, 1);
        run_commit(0);
        if (n > 8) check_commit(base, n, off, "R4");
        else if (n == 1) check_commit(base, n, off, "R11");
        else if (n % 2 == 1) check_commit(base, n, off, "R9");
        else check_commit(base, n, off, "R3");
      end
    end

    // R5: repeated START discards buffered bytes
    pb = 0;
    pulse(0, 0, 0, 0, 1, 0, pb);
    pulse(1, 8'h40, 0, 0, 0, 0, pb);
    for (int k = 0; k < 3; k++) pulse(0, 0, 1, 8'(k + 1), 0, 0, pb);
    pulse(0, 0, 0, 0, 1, 0, pb);
    pulse(0, 0, 0, 0, 0, 1, pb);
    expect_quiet(4, "R5");

    // R8: address only, then STOP
    pulse(0, 0, 0, 0, 1, 0, pb);
    pulse(1, 8'h22, 0, 0, 0, 0, pb);
    pulse(0, 0, 0, 0, 0, 1, pb);
    expect_quiet(4, "R8");

    // R10: START together with STOP commits
    pulse(0, 0, 0, 0, 1, 0, pb);
    pulse(1, 8'h5D, 0, 0, 0, 0, pb);
    pulse(0, 0, 1, 8'h11, 0, 0, pb);
    pulse(0, 0, 1, 8'h22, 0, 0, pb);
    pulse(0, 0, 0, 0, 1, 1, pb);
    run_commit(0);
    chk(got_n == 2, "R10", got_n, 2);
    chk(got_addr[0] == 8'h5D && got_data[0] == 8'h11, "R10", got_data[0], 8'h11);
    chk(got_addr[1] == 8'h5E && got_data[1] == 8'h22, "R10", got_data[1], 8'h22);

    // R7: inputs during busy are ignored; commit unaffected; lone STOP after
    pulse(0, 0, 0, 0, 1, 0, pb);
    pulse(1, 8'h87, 0, 0, 0, 0, pb);
    pulse(0, 0, 1, 8'h31, 0, 0, pb);
    pulse(0, 0, 1, 8'h32, 0, 1, pb);
    run_commit(1);
    chk(got_n == 2, "R7", got_n, 2);
    chk(busy_len == WR, "R7", busy_len, WR);
    chk(got_addr[0] == 8'h87 && got_data[0] == 8'h31, "R7", got_data[0], 8'h31);
    chk(got_addr[1] == 8'h80 && got_data[1] == 8'h32, "R7", got_addr[1], 8'h80);
    pulse(0, 0, 0, 0, 0, 1, pb);
    expect_quiet(4, "R7");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule